// File: doc/BRIEF.md
# Exponential Time-Constant Tracking Observer

This block estimates the time constant of a capacitor voltage that decays towards zero, or rises towards a known supply level, from a stream of unsigned voltage codes. A run begins with a start pulse. The pulse also captures the phase: in discharge mode the tracked quantity is the code itself, and in charge mode it is the supply level minus the code. The block turns that quantity into a fixed-point base-2 logarithm. A second-order proportional-integral loop then follows the slope of the logarithm, one step per accepted sample. After each step an iterative divider converts the slope into a time-constant estimate, counted in samples.

The run ends by itself with `done` when the running estimate falls at or below 2.5 times the number of loop steps taken. It ends with `error` when the tracked quantity is zero or negative, or when the step budget runs out first. The loop gains, the starting slope and the step budget come in on configuration inputs, which must stay steady during a run. Samples must be spaced at least 21 clock cycles apart.

Top module: `tc_observer`

## Requirements
- R1: After reset, `tEst` is 0 and `done` and `error` are both 0.
- R2: A `start` pulse clears `tEst`, `done` and `error` on the next cycle, even in the middle of a run. It captures `mode` (0 = discharge, 1 = charge) and `chargeLevel`, and begins a new run.
- R3: The tracked value y is `sample` in discharge mode and `chargeLevel - sample` in charge mode. When an accepted sample gives y <= 0, `error` is set and the run ends.
- R4: The logarithm is z = 256·(256·p + L[m]) in a format with 16 fraction bits. Here p is the bit position of the leading one of y, m is the 4 bits just below that one (zero-filled), and L[m] = round(256·log2(1 + m/16)).
- R5: The first accepted sample of a run sets zhat = z, c = `initSlope` and the previous error to 0, with step count n = 0. It changes no output.
- R6: Each later accepted sample sets zhat += c (using the old c) and e = z - zhat. It then sets c += ((e - ePrev)·`gainP`) >>> 16 + (ePrev·`gainI`) >>> 16, then ePrev = e and n += 1. All values are 32-bit two's complement, and the shifts round down.
- R7: After each loop step, `tEst` = min(floor(94548 / |c|), 65535), with c = 0 giving 65535. `tEst` shows this value within 20 cycles of the accepted sample.
- R8: When 2·`tEst` <= 5·n after a step, `done` rises and the run ends.
- R9: When a step does not meet R8 and n >= `maxSamples`, `error` rises and the run ends.
- R10: Once `done` or `error` is set, further samples change nothing until the next `start`.
- R11: `done` and `error` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new run; captures mode and level |
| mode | input | 1 | 0 = discharge, 1 = charge |
| chargeLevel | input | 12 | Steady-state supply level code for charge mode |
| gainP | input | 18 | Proportional coefficient, signed, 16 fraction bits |
| gainI | input | 18 | Integral coefficient, signed, 16 fraction bits |
| initSlope | input | 32 | Starting slope, signed, 16 fraction bits |
| maxSamples | input | 16 | Step budget before timeout |
| sampleValid | input | 1 | Sample strobe |
| sample | input | 12 | Voltage code |
| tEst | output | 16 | Time-constant estimate in samples |
| done | output | 1 | Stopping rule met |
| error | output | 1 | Non-positive value or timeout |

## Verification
A wrong slope, error history or predicted logarithm shows up in `tEst` one sample later, within 20 cycles, because every step publishes a fresh quotient. A bad step counter or comparison shows up as `done` or `error` rising one sample early or late. A slip in the logarithm mantissa table moves the quotient only for codes whose mantissa bits hit the wrong entry. For that reason the stimulus covers exact powers of two as well as random decays.

// File: rtl/tc_obs_pkg.sv
package tc_obs_pkg;

  localparam int LUT_BITS = 4;
  localparam int LOG_FRAC = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_WAIT,
    ST_DIV,
    ST_CHECK
  } ctrlState_t;

  typedef struct packed {
    logic clearAll;
    logic loadFirst;
    logic stepLoop;
    logic divStep;
    logic commit;
  } dpStrobe_t;

  // round(256 * log2(1 + m/16))
  function automatic logic [LOG_FRAC-1:0] mantLog(input logic [LUT_BITS-1:0] m);
    logic [LOG_FRAC-1:0] r;
    case (m)
      4'd0:  r = 8'd0;
      4'd1:  r = 8'd22;
      4'd2:  r = 8'd44;
      4'd3:  r = 8'd63;
      4'd4:  r = 8'd82;
      4'd5:  r = 8'd100;
      4'd6:  r = 8'd118;
      4'd7:  r = 8'd134;
      4'd8:  r = 8'd150;
      4'd9:  r = 8'd165;
      4'd10: r = 8'd179;
      4'd11: r = 8'd193;
      4'd12: r = 8'd207;
      4'd13: r = 8'd220;
      4'd14: r = 8'd232;
      default: r = 8'd244;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tc_obs_log2.sv
module tc_obs_log2 #(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0] yIn,
  output logic [$clog2(DATA_W)+tc_obs_pkg::LOG_FRAC-1:0] logOut
);
  import tc_obs_pkg::*;

  localparam int POS_W = $clog2(DATA_W);

  logic [POS_W-1:0]           leadPos;
  logic [DATA_W+LUT_BITS-1:0] wideY;
  logic [LUT_BITS-1:0]        mant;

  always_comb begin
    leadPos = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (yIn[i]) leadPos = POS_W'(i);
    end
    wideY  = {yIn, {LUT_BITS{1'b0}}};
    mant   = LUT_BITS'(wideY >> leadPos);
    logOut = {leadPos, mantLog(mant)};
  end

endmodule

// File: rtl/tc_obs_datapath.sv
module tc_obs_datapath
  import tc_obs_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int CO_W      = 18,
  parameter int ACC_W     = 32,
  parameter int FRAC      = 16,
  parameter int CNT_W     = 16,
  parameter int T_W       = 16,
  parameter int RECIP_NUM = 94548
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              mode,
  input  logic [DATA_W-1:0] chargeLevel,
  input  logic [CO_W-1:0]   gainP,
  input  logic [CO_W-1:0]   gainI,
  input  logic [ACC_W-1:0]  initSlope,
  input  logic [CNT_W-1:0]  maxSamples,
  input  logic [DATA_W-1:0] sample,
  output logic [T_W-1:0]    tEst,
  output logic [CNT_W-1:0]  stepCount,
  output logic              yBad,
  output logic              divLast,
  output logic              stopHit,
  output logic              timeoutHit
);

  localparam int LOG_W  = $clog2(DATA_W) + LOG_FRAC;
  localparam int ZSH    = FRAC - LOG_FRAC;
  localparam int PROD_W = ACC_W + CO_W;
  localparam int NUM_W  = $clog2(RECIP_NUM + 1);
  localparam int DCNT_W = $clog2(NUM_W);
  localparam int CMP_W  = T_W + CNT_W + 4;

  logic              modeR;
  logic [DATA_W-1:0] levelR;
  logic [DATA_W:0]   yExt;
  logic [LOG_W-1:0]  logVal;

  logic signed [ACC_W-1:0]  zNow, zhat, chat, epsPrev;
  logic signed [ACC_W-1:0]  zhatNext, epsNow, dEps, termP, termI, chatNext;
  logic signed [PROD_W-1:0] prodP, prodI;
  logic [ACC_W-1:0]         chatMag;

  logic [ACC_W-1:0]  divRem, divDen;
  logic [NUM_W-1:0]  divQuo;
  logic [DCNT_W-1:0] divCnt;
  logic [ACC_W:0]    remShift, remDiff;
  logic              remFits;
  logic [T_W-1:0]    tSat;

  // observed value and its logarithm
  always_comb begin
    if (modeR) yExt = {1'b0, levelR} - {1'b0, sample};
    else       yExt = {1'b0, sample};
    yBad = yExt[DATA_W] || (yExt == '0);
  end

  tc_obs_log2 #(.DATA_W(DATA_W)) u_log (
    .yIn   (yExt[DATA_W-1:0]),
    .logOut(logVal)
  );

  // tracking loop arithmetic
  always_comb begin
    zNow     = $signed(ACC_W'(logVal) << ZSH);
    zhatNext = zhat + chat;
    epsNow   = zNow - zhatNext;
    dEps     = epsNow - epsPrev;
    prodP    = $signed({{(PROD_W-ACC_W){dEps[ACC_W-1]}}, dEps}
                     * {{(PROD_W-CO_W){gainP[CO_W-1]}}, gainP});
    prodI    = $signed({{(PROD_W-ACC_W){epsPrev[ACC_W-1]}}, epsPrev}
                     * {{(PROD_W-CO_W){gainI[CO_W-1]}}, gainI});
    termP    = ACC_W'(prodP >>> FRAC);
    termI    = ACC_W'(prodI >>> FRAC);
    chatNext = chat + termP + termI;
    chatMag  = chatNext[ACC_W-1] ? (~chatNext + 1'b1) : chatNext;
  end

  // restoring divider step
  always_comb begin
    remShift = {divRem, divQuo[NUM_W-1]};
    remFits  = remShift >= {1'b0, divDen};
    remDiff  = remShift - {1'b0, divDen};
    divLast  = (divCnt == '0);
  end

  generate
    if (NUM_W > T_W) begin : g_sat
      assign tSat = (|divQuo[NUM_W-1:T_W]) ? '1 : divQuo[T_W-1:0];
    end else begin : g_ext
      assign tSat = T_W'(divQuo);
    end
  endgenerate

  assign stopHit    = (CMP_W'(tSat) << 1) <= (CMP_W'(stepCount) * CMP_W'(5));
  assign timeoutHit = stepCount >= maxSamples;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeR     <= 1'b0;
      levelR    <= '0;
      zhat      <= '0;
      chat      <= '0;
      epsPrev   <= '0;
      stepCount <= '0;
      tEst      <= '0;
      divRem    <= '0;
      divDen    <= '0;
      divQuo    <= '0;
      divCnt    <= '0;
    end else begin
      if (stb.clearAll) begin
        modeR     <= mode;
        levelR    <= chargeLevel;
        tEst      <= '0;
        stepCount <= '0;
      end
      if (stb.loadFirst) begin
        zhat      <= zNow;
        chat      <= $signed(initSlope);
        epsPrev   <= '0;
        stepCount <= '0;
      end
      if (stb.stepLoop) begin
        zhat      <= zhatNext;
        chat      <= chatNext;
        epsPrev   <= epsNow;
        stepCount <= stepCount + 1'b1;
        divDen    <= chatMag;
        divRem    <= '0;
        divQuo    <= NUM_W'(RECIP_NUM);
        divCnt    <= DCNT_W'(NUM_W - 1);
      end
      if (stb.divStep) begin
        divRem <= remFits ? ACC_W'(remDiff) : ACC_W'(remShift);
        divQuo <= {divQuo[NUM_W-2:0], remFits};
        divCnt <= divCnt - 1'b1;
      end
      if (stb.commit) begin
        tEst <= tSat;
      end
    end
  end

endmodule

// File: rtl/tc_obs_control.sv
module tc_obs_control
  import tc_obs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      sampleValid,
  input  logic      yBad,
  input  logic      divLast,
  input  logic      stopHit,
  input  logic      timeoutHit,
  output dpStrobe_t stb,
  output logic      done,
  output logic      error,
  output logic      inCheck
);

  ctrlState_t state, nextState;
  logic       setDone, setError;

  always_comb begin
    stb       = '0;
    nextState = state;
    setDone   = 1'b0;
    setError  = 1'b0;
    if (start) begin
      stb.clearAll = 1'b1;
      nextState    = ST_FIRST;
    end else begin
      case (state)
        ST_FIRST: if (sampleValid) begin
          if (yBad) begin
            setError  = 1'b1;
            nextState = ST_IDLE;
          end else begin
            stb.loadFirst = 1'b1;
            nextState     = ST_WAIT;
          end
        end
        ST_WAIT: if (sampleValid) begin
          if (yBad) begin
            setError  = 1'b1;
            nextState = ST_IDLE;
          end else begin
            stb.stepLoop = 1'b1;
            nextState    = ST_DIV;
          end
        end
        ST_DIV: begin
          stb.divStep = 1'b1;
          if (divLast) nextState = ST_CHECK;
        end
        ST_CHECK: begin
          stb.commit = 1'b1;
          if (stopHit) begin
            setDone   = 1'b1;
            nextState = ST_IDLE;
          end else if (timeoutHit) begin
            setError  = 1'b1;
            nextState = ST_IDLE;
          end else begin
            nextState = ST_WAIT;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assign inCheck = (state == ST_CHECK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= nextState;
      if (start) begin
        done  <= 1'b0;
        error <= 1'b0;
      end else begin
        if (setDone)  done  <= 1'b1;
        if (setError) error <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tc_observer.sv
module tc_observer
  import tc_obs_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int CO_W      = 18,
  parameter int ACC_W     = 32,
  parameter int FRAC      = 16,
  parameter int CNT_W     = 16,
  parameter int T_W       = 16,
  parameter int RECIP_NUM = 94548
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              mode,
  input  logic [DATA_W-1:0] chargeLevel,
  input  logic [CO_W-1:0]   gainP,
  input  logic [CO_W-1:0]   gainI,
  input  logic [ACC_W-1:0]  initSlope,
  input  logic [CNT_W-1:0]  maxSamples,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sample,
  output logic [T_W-1:0]    tEst,
  output logic              done,
  output logic              error
);

  dpStrobe_t        stb;
  logic             yBad, divLast, stopHit, timeoutHit, inCheck;
  logic [CNT_W-1:0] stepCount;

  tc_obs_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .sampleValid(sampleValid),
    .yBad       (yBad),
    .divLast    (divLast),
    .stopHit    (stopHit),
    .timeoutHit (timeoutHit),
    .stb        (stb),
    .done       (done),
    .error      (error),
    .inCheck    (inCheck)
  );

  tc_obs_datapath #(
    .DATA_W(DATA_W), .CO_W(CO_W), .ACC_W(ACC_W), .FRAC(FRAC),
    .CNT_W(CNT_W), .T_W(T_W), .RECIP_NUM(RECIP_NUM)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .mode       (mode),
    .chargeLevel(chargeLevel),
    .gainP      (gainP),
    .gainI      (gainI),
    .initSlope  (initSlope),
    .maxSamples (maxSamples),
    .sample     (sample),
    .tEst       (tEst),
    .stepCount  (stepCount),
    .yBad       (yBad),
    .divLast    (divLast),
    .stopHit    (stopHit),
    .timeoutHit (timeoutHit)
  );

endmodule

// File: rtl/tc_observer_checker.sv
module tc_observer_checker #(
  parameter int CNT_W = 16,
  parameter int T_W   = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             done,
  input logic             error,
  input logic             inCheck,
  input logic [T_W-1:0]   tEst,
  input logic [CNT_W-1:0] stepCount,
  input logic [CNT_W-1:0] maxSamples
);

  localparam int CMP_W = T_W + CNT_W + 4;

  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!done && !error && tEst == '0));

  assert_done_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(tEst)));

  assert_error_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (error && !start) |=> (error && $stable(tEst)));

  assert_stop_rule_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ((CMP_W'(tEst) << 1) <= (CMP_W'(stepCount) * CMP_W'(5))));

  assert_timeout_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(error) && $past(inCheck)) |-> (stepCount >= maxSamples));

endmodule

bind tc_observer tc_observer_checker #(.CNT_W(CNT_W), .T_W(T_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .done      (done),
  .error     (error),
  .inCheck   (inCheck),
  .tEst      (tEst),
  .stepCount (stepCount),
  .maxSamples(maxSamples)
);

// File: tb/tc_observer_bench.sv
module tc_observer_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [11:0] chargeLevel = '0;
  logic [17:0] gainP = '0;
  logic [17:0] gainI = '0;
  logic [31:0] initSlope = '0;
  logic [15:0] maxSamples = '0;
  logic        sampleValid = 1'b0;
  logic [11:0] sample = '0;
  logic [15:0] tEst;
  logic        done, error;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit mActive, mFirst, mMode, mDone, mErr;
  int mLevel, mGp, mGi, mInit, mMax;
  int mZhat, mChat, mEps, mN, mT;

  always #(CLK_PERIOD/2) clk = ~clk;

  tc_observer u_tc_observer (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .chargeLevel(chargeLevel), .gainP(gainP), .gainI(gainI),
    .initSlope(initSlope), .maxSamples(maxSamples),
    .sampleValid(sampleValid), .sample(sample),
    .tEst(tEst), .done(done), .error(error)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // R4: logarithm in 16 fraction bits
  function automatic int logQ16(int y);
    int  p = 0;
    int  m;
    real lr;
    for (int i = 0; i < 12; i++) if (y >= (1 << i)) p = i;
    m  = ((y << 4) >> p) & 15;
    lr = $ln(1.0 + m / 16.0) / $ln(2.0) * 256.0;
    return ((p * 256) + $rtoi(lr + 0.5)) << 8;
  endfunction

  function automatic int mulQ(int a, int b);
    longint pr = longint'(a) * longint'(b);
    return int'(pr >>> 16);
  endfunction

  task automatic outputsCheck(string req);
    check(req, "tEst", tEst, mT);
    check(req, "done", done, mDone);
    check(req, "error", error, mErr);
  endtask

  task automatic doStart(bit md, int lvl, int gp, int gi, int init, int mx);
    @(negedge clk);
    mode = md; chargeLevel = 12'(lvl); gainP = 18'(gp); gainI = 18'(gi);
    initSlope = 32'(init); maxSamples = 16'(mx); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mActive = 1; mFirst = 1; mMode = md; mLevel = lvl; mGp = gp; mGi = gi;
    mInit = init; mMax = mx; mDone = 0; mErr = 0; mT = 0;
    outputsCheck("R2");
  endtask

  task automatic sendSample(int s, string req);
    int     y, z, e;
    longint mag, q;
    @(negedge clk);
    sampleValid = 1'b1; sample = 12'(s);
    @(negedge clk);
    sampleValid = 1'b0;
    if (mActive) begin
      y = mMode ? (mLevel - s) : s;
      if (y <= 0) begin
        mErr = 1; mActive = 0;
      end else begin
        z = logQ16(y);
        if (mFirst) begin
          mZhat = z; mChat = mInit; mEps = 0; mN = 0; mFirst = 0;
        end else begin
          mZhat = mZhat + mChat;
          e = z - mZhat;
          mChat = mChat + mulQ(e - mEps, mGp) + mulQ(mEps, mGi);
          mEps = e;
          mN++;
          mag = (mChat < 0) ? -longint'(mChat) : longint'(mChat);
          q = (mag == 0) ? 131071 : 94548 / mag;
          mT = (q > 65535) ? 65535 : int'(q);
          if (2 * mT <= 5 * mN) begin
            mDone = 1; mActive = 0;
          end else if (mN >= mMax) begin
            mErr = 1; mActive = 0;
          end
        end
      end
    end
    repeat (21) @(negedge clk);
    outputsCheck(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "tEst", tEst, 0);
    check("R1", "done", done, 0);
    check("R1", "error", error, 0);

    // R5 R6 R7 R8: constant samples, steep initial slope, stops on step 1
    doStart(0, 0, 32768, 4096, -65536, 50);
    sendSample(1000, "R5");
    check("R5", "done after first", done, 0);
    sendSample(1000, "R8");
    check("R7", "tEst literal", tEst, 2);
    check("R8", "done literal", done, 1);
    // R10: sample after done is ignored
    sendSample(10, "R10");
    check("R10", "tEst held", tEst, 2);

    // R4: exact octave drop gives slope -1.0
    doStart(0, 0, 65536, 0, 0, 50);
    sendSample(2048, "R4");
    sendSample(1024, "R4");
    check("R4", "octave tEst", tEst, 1);
    // R4: mantissa entry 8
    doStart(0, 0, 65536, 0, 0, 50);
    sendSample(3072, "R4");
    sendSample(3000, "R4");

    // R9: flat input with zero slope never stops
    doStart(0, 0, 32768, 4096, 0, 3);
    for (int k = 0; k < 4; k++) sendSample(500, "R9");
    check("R9", "timeout error", error, 1);
    check("R7", "zero slope saturates", tEst, 65535);
    sendSample(500, "R10");

    // R3: zero code in discharge
    doStart(0, 0, 32768, 4096, 0, 50);
    sendSample(0, "R3");
    check("R3", "zero y error", error, 1);
    // R3: charge sample reaching the level
    doStart(1, 3000, 32768, 4096, -2000, 50);
    sendSample(1000, "R3");
    sendSample(1500, "R3");
    sendSample(3000, "R3");
    check("R3", "charge y<=0 error", error, 1);

    // R2: restart mid-run
    doStart(1, 3500, 32768, 4096, -1000, 80);
    sendSample(200, "R6");
    sendSample(600, "R6");
    doStart(0, 0, 32768, 4096, -1000, 80);
    check("R2", "restart clears tEst", tEst, 0);

    // R3 R4 R6 R7 R8 R9 R11: random exponential runs
    for (int r = 0; r < 20; r++) begin
      bit  md   = 1'($urandom % 2);
      int  lvl  = 3500 + int'($urandom % 500);
      int  amp  = 1500 + int'($urandom % 1900);
      int  tau  = 8 + int'($urandom % 60);
      int  gp   = 16384 * (1 + int'($urandom % 3));
      int  gi   = 1024 << ($urandom % 4);
      int  mx   = 30 + int'($urandom % 90);
      doStart(md, lvl, gp, gi, -int'($urandom % 3000), mx);
      for (int k = 0; k < mx + 2 && mActive; k++) begin
        real v = amp * $exp(-k / real'(tau));
        int  s = md ? (lvl - $rtoi(v)) : $rtoi(v);
        s = s + int'($urandom % 5) - 2;
        if (s < 0) s = 0;
        if (s > 4095) s = 4095;
        sendSample(s, "R6");
        check("R11", "exclusive flags", done && error, 0);
      end
    end

    summary();
  end

endmodule